// File: doc/BRIEF.md
# Temperature Limit Alert Controller

This block watches a stream of 12-bit signed temperature samples and decides when a temperature alert is raised. Each sample is checked against a programmable upper limit and a programmable lower limit. A filter requires a chosen number of consecutive qualifying samples before the block reacts. The result is driven on an alert pin and is also shown as a readable status bit.

The alert can work in two ways. In comparator mode it follows a hysteresis band. In latched interrupt mode it raises an event on the upper limit and on the lower limit in turn. Each event stays until software acknowledges it. A polarity bit sets the active level of the pin and inverts the status value. While the sensor is shut down, software can ask for a single conversion. The block then issues one conversion-start request.

The analog converter and the serial bus sit outside this block. Register writes and reads reach it as single-cycle strobes.

Top module: `temp_alert_ctrl`

## Requirements
- R1: After reset, and in the cycle after a general-call reset strobe, the block returns to its defaults. The upper limit is 12'h500 and the lower limit is 12'h4B0. The mode is comparator, the polarity bit is 0, the fault selection is 0, and no one-shot is pending. The alert is inactive (pin high) and the status bit reads 0.
- R2: In comparator mode the alert becomes active after the required number of consecutive valid samples with sample >= upper limit.
- R3: Once active, the comparator alert stays active until the required number of consecutive valid samples with sample < lower limit. The status bit always shows this comparator state, whatever the mode bit holds, and changes only on a valid sample, a configuration write or a general-call reset.
- R4: The fault selection maps 0, 1, 2 and 3 to 1, 2, 4 and 6 consecutive samples. Any valid sample that fails the condition being watched restarts the count.
- R5: In interrupt mode the alert becomes active after the required number of consecutive samples at or above the upper limit. It then stays active regardless of later samples.
- R6: In interrupt mode an active alert is cleared in the cycle after any of three events: a register-read strobe, an alert-response acknowledge strobe, or a rising edge of the shutdown flag.
- R7: After an interrupt alert raised on the upper limit, the next alert can be raised only by samples below the lower limit. The alert after that is raised on the upper limit again, and the two keep alternating.
- R8: With the polarity bit at 0 the pin is driven low when the alert is active, and the status bit shows the comparator state as is. With the polarity bit at 1 the pin is driven high when active, and the status bit shows the inverted comparator state.
- R9: Samples and limits are compared as full 12-bit two's-complement values. Negative values and the least significant bits take part in every comparison.
- R10: A configuration write with the one-shot bit set while the shutdown flag is high produces a single one-cycle conversion-start pulse in the next cycle. Further one-shot writes give no pulse until a valid sample arrives or shutdown is left. One-shot writes outside shutdown give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | A new temperature sample is present |
| sampleData | input | 12 | Signed temperature sample, 0.0625 degree per LSB |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIntMode | input | 1 | Written mode: 0 comparator, 1 interrupt |
| cfgPolarity | input | 1 | Written polarity: 0 active-low pin, 1 active-high pin |
| cfgFaultSel | input | 2 | Written consecutive-fault selection |
| cfgOneShot | input | 1 | Written one-shot request bit |
| limWe | input | 1 | Limit write strobe |
| limSelHigh | input | 1 | Limit select: 1 upper, 0 lower |
| limData | input | 12 | Limit value to write |
| regRead | input | 1 | Any register read strobe |
| alertAck | input | 1 | Alert-response acknowledged strobe |
| genCallReset | input | 1 | General-call reset strobe |
| shutdown | input | 1 | Sensor is in shutdown |
| alertPin | output | 1 | Alert pin level |
| statusBit | output | 1 | Readable alert status bit |
| convStart | output | 1 | Conversion-start request pulse |

## Verification
On every cycle the assertions check the following. The pin and the status bit disagree in comparator mode. The status bit holds when there is no sample, configuration write or reset. A read or acknowledge without a sample leaves the interrupt alert inactive. A conversion-start pulse lasts one cycle and only follows shutdown. The pin and status return to their idle values after a general-call reset. The bench scenarios are needed to show the rest: the exact fault counts, the high/low alternation of the interrupt mode, signed and LSB-level limit comparisons, and one-shot suppression while a conversion is pending.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int TEMP_W = 12;
  localparam int CNT_W  = 3;

  typedef struct packed {
    logic intMode;
    logic polarity;
    logic [1:0] faultSel;
  } cfgReg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic compWatchLow;
    logic intWatchLow;
    logic intHold;
    logic intEnable;
  } ctrlStrobe_t;

  function automatic logic [CNT_W-1:0] faultLimit(input logic [1:0] sel);
    case (sel)
      2'd0: faultLimit = CNT_W'(1);
      2'd1: faultLimit = CNT_W'(2);
      2'd2: faultLimit = CNT_W'(4);
      default: faultLimit = CNT_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/tac_fault_filter.sv
module tac_fault_filter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softReset,
  input  logic             hold,
  input  logic             sampleValid,
  input  logic             condMet,
  input  logic [CNT_W-1:0] limitN,
  output logic             trip
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nextCnt;

  assign nextCnt = cnt + CNT_W'(1);
  assign trip = sampleValid && !hold && !softReset && condMet && (nextCnt >= limitN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (softReset || hold) begin
      cnt <= '0;
    end else if (sampleValid) begin
      if (!condMet || trip) cnt <= '0;
      else                  cnt <= nextCnt;
    end
  end
endmodule

// File: rtl/tac_datapath.sv
module tac_datapath
  import tac_pkg::*;
#(
  parameter int                 DW        = 12,
  parameter logic [DW-1:0]      THIGH_RST = 12'h500,
  parameter logic [DW-1:0]      TLOW_RST  = 12'h4B0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleValid,
  input  logic [DW-1:0] sampleData,
  input  logic          cfgWe,
  input  logic          cfgIntMode,
  input  logic          cfgPolarity,
  input  logic [1:0]    cfgFaultSel,
  input  logic          limWe,
  input  logic          limSelHigh,
  input  logic [DW-1:0] limData,
  input  logic          genCallReset,
  input  ctrlStrobe_t   ctrl,
  output cfgReg_t       cfgQ,
  output logic          compTrip,
  output logic          intTrip
);
  localparam int NFILT = 2;

  logic [DW-1:0] limHigh;
  logic [DW-1:0] limLow;
  logic          hiHit;
  logic          loHit;
  logic [NFILT-1:0] condArr;
  logic [NFILT-1:0] holdArr;
  logic [NFILT-1:0] tripArr;
  logic [CNT_W-1:0] limitN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      limHigh <= THIGH_RST;
      limLow  <= TLOW_RST;
    end else if (genCallReset) begin
      cfgQ    <= '0;
      limHigh <= THIGH_RST;
      limLow  <= TLOW_RST;
    end else begin
      if (cfgWe) begin
        cfgQ.intMode  <= cfgIntMode;
        cfgQ.polarity <= cfgPolarity;
        cfgQ.faultSel <= cfgFaultSel;
      end
      if (limWe) begin
        if (limSelHigh) limHigh <= limData;
        else            limLow  <= limData;
      end
    end
  end

  assign hiHit  = $signed(sampleData) >= $signed(limHigh);
  assign loHit  = $signed(sampleData) <  $signed(limLow);
  assign limitN = faultLimit(cfgQ.faultSel);

  assign condArr[0] = ctrl.compWatchLow ? loHit : hiHit;
  assign holdArr[0] = 1'b0;
  assign condArr[1] = ctrl.intWatchLow ? loHit : hiHit;
  assign holdArr[1] = ctrl.intHold || !ctrl.intEnable;

  for (genvar g = 0; g < NFILT; g++) begin : gFilt
    tac_fault_filter #(.CNT_W(CNT_W)) uFilt (
      .clk        (clk),
      .rstN       (rstN),
      .softReset  (genCallReset),
      .hold       (holdArr[g]),
      .sampleValid(sampleValid),
      .condMet    (condArr[g]),
      .limitN     (limitN),
      .trip       (tripArr[g])
    );
  end

  assign compTrip = tripArr[0];
  assign intTrip  = tripArr[1];
endmodule

// File: rtl/tac_control.sv
module tac_control
  import tac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  cfgReg_t     cfgQ,
  input  logic        compTrip,
  input  logic        intTrip,
  input  logic        sampleValid,
  input  logic        cfgWe,
  input  logic        cfgOneShot,
  input  logic        regRead,
  input  logic        alertAck,
  input  logic        genCallReset,
  input  logic        shutdown,
  output ctrlStrobe_t ctrl,
  output logic        alertPin,
  output logic        statusBit,
  output logic        convStart
);
  logic compState;
  logic intAlert;
  logic intArmHigh;
  logic shutdownQ;
  logic oneShotPend;
  logic convStartQ;
  logic oneShotGo;
  logic intClear;
  logic alertActive;

  assign intClear  = regRead || alertAck || (shutdown && !shutdownQ);
  assign oneShotGo = cfgWe && cfgOneShot && shutdown && !oneShotPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      compState   <= 1'b0;
      intAlert    <= 1'b0;
      intArmHigh  <= 1'b1;
      shutdownQ   <= 1'b0;
      oneShotPend <= 1'b0;
      convStartQ  <= 1'b0;
    end else begin
      shutdownQ <= shutdown;
      if (genCallReset) begin
        compState   <= 1'b0;
        intAlert    <= 1'b0;
        intArmHigh  <= 1'b1;
        oneShotPend <= 1'b0;
        convStartQ  <= 1'b0;
      end else begin
        if (compTrip) compState <= !compState;

        if (!cfgQ.intMode) begin
          intAlert   <= 1'b0;
          intArmHigh <= 1'b1;
        end else if (intTrip) begin
          intAlert   <= 1'b1;
          intArmHigh <= !intArmHigh;
        end else if (intClear) begin
          intAlert   <= 1'b0;
        end

        convStartQ <= oneShotGo;
        if (oneShotGo)                      oneShotPend <= 1'b1;
        else if (sampleValid || !shutdown)  oneShotPend <= 1'b0;
      end
    end
  end

  assign ctrl.compWatchLow = compState;
  assign ctrl.intWatchLow  = !intArmHigh;
  assign ctrl.intHold      = intAlert;
  assign ctrl.intEnable    = cfgQ.intMode;

  assign alertActive = cfgQ.intMode ? intAlert : compState;
  assign alertPin    = !(alertActive ^ cfgQ.polarity);
  assign statusBit   = compState ^ cfgQ.polarity;
  assign convStart   = convStartQ;
endmodule

// File: rtl/temp_alert_ctrl.sv
module temp_alert_ctrl
  import tac_pkg::*;
#(
  parameter logic [TEMP_W-1:0] THIGH_RST = 12'h500,
  parameter logic [TEMP_W-1:0] TLOW_RST  = 12'h4B0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sampleData,
  input  logic              cfgWe,
  input  logic              cfgIntMode,
  input  logic              cfgPolarity,
  input  logic [1:0]        cfgFaultSel,
  input  logic              cfgOneShot,
  input  logic              limWe,
  input  logic              limSelHigh,
  input  logic [TEMP_W-1:0] limData,
  input  logic              regRead,
  input  logic              alertAck,
  input  logic              genCallReset,
  input  logic              shutdown,
  output logic              alertPin,
  output logic              statusBit,
  output logic              convStart
);
  cfgReg_t     cfgQ;
  ctrlStrobe_t ctrl;
  logic        compTrip;
  logic        intTrip;

  tac_datapath #(
    .DW(TEMP_W), .THIGH_RST(THIGH_RST), .TLOW_RST(TLOW_RST)
  ) uDp (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .cfgWe(cfgWe), .cfgIntMode(cfgIntMode), .cfgPolarity(cfgPolarity),
    .cfgFaultSel(cfgFaultSel), .limWe(limWe), .limSelHigh(limSelHigh),
    .limData(limData), .genCallReset(genCallReset), .ctrl(ctrl),
    .cfgQ(cfgQ), .compTrip(compTrip), .intTrip(intTrip)
  );

  tac_control uCtl (
    .clk(clk), .rstN(rstN), .cfgQ(cfgQ), .compTrip(compTrip), .intTrip(intTrip),
    .sampleValid(sampleValid), .cfgWe(cfgWe), .cfgOneShot(cfgOneShot),
    .regRead(regRead), .alertAck(alertAck), .genCallReset(genCallReset),
    .shutdown(shutdown), .ctrl(ctrl), .alertPin(alertPin),
    .statusBit(statusBit), .convStart(convStart)
  );
endmodule

// File: rtl/tac_checker.sv
module tac_checker (
  input logic clk,
  input logic rstN,
  input logic genCallReset,
  input logic regRead,
  input logic alertAck,
  input logic sampleValid,
  input logic cfgWe,
  input logic shutdown,
  input logic alertPin,
  input logic statusBit,
  input logic convStart,
  input logic intMode,
  input logic polarity
);
  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  a_r1_gcr_defaults: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(genCallReset)) |-> (alertPin && !statusBit));

  a_r3_comp_pin_vs_status: assert property (@(posedge clk) disable iff (!rstN)
    !intMode |-> (alertPin != statusBit));

  a_r3_status_holds: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !$past(sampleValid) && !$past(cfgWe) && !$past(genCallReset))
      |-> $stable(statusBit));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && intMode && !$past(cfgWe) && !$past(genCallReset) &&
     !$past(sampleValid) && ($past(regRead) || $past(alertAck)))
      |-> (alertPin == !polarity));

  a_r10_conv_single: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  a_r10_conv_in_shutdown: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && convStart) |-> $past(shutdown));
endmodule

bind temp_alert_ctrl tac_checker uChk (
  .clk(clk), .rstN(rstN), .genCallReset(genCallReset), .regRead(regRead),
  .alertAck(alertAck), .sampleValid(sampleValid), .cfgWe(cfgWe),
  .shutdown(shutdown), .alertPin(alertPin), .statusBit(statusBit),
  .convStart(convStart), .intMode(cfgQ.intMode), .polarity(cfgQ.polarity)
);

// File: tb/sim_temp_alert_ctrl.sv
module sim_temp_alert_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [11:0] sampleData = '0;
  logic cfgWe = 1'b0, cfgIntMode = 1'b0, cfgPolarity = 1'b0, cfgOneShot = 1'b0;
  logic [1:0] cfgFaultSel = '0;
  logic limWe = 1'b0, limSelHigh = 1'b0;
  logic [11:0] limData = '0;
  logic regRead = 1'b0, alertAck = 1'b0, genCallReset = 1'b0, shutdown = 1'b0;
  logic alertPin, statusBit, convStart;

  temp_alert_ctrl u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .cfgWe(cfgWe), .cfgIntMode(cfgIntMode), .cfgPolarity(cfgPolarity),
    .cfgFaultSel(cfgFaultSel), .cfgOneShot(cfgOneShot), .limWe(limWe),
    .limSelHigh(limSelHigh), .limData(limData), .regRead(regRead),
    .alertAck(alertAck), .genCallReset(genCallReset), .shutdown(shutdown),
    .alertPin(alertPin), .statusBit(statusBit), .convStart(convStart)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  logic [11:0] mHigh, mLow;
  logic mInt, mPol, mComp, mIntAlert, mArmHigh, mPend, mConv, mShutQ;
  logic [1:0] mFault;
  int mCompCnt, mIntCnt;
  int nChecks = 0, nFails = 0;
  bit done = 0;
  string curReq = "R1";

  function automatic int needN(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic logic expPin();
    return !((mInt ? mIntAlert : mComp) ^ mPol);
  endfunction

  function automatic logic expStatus();
    return mComp ^ mPol;
  endfunction

  task automatic modelReset();
    mHigh = 12'h500; mLow = 12'h4B0; mInt = 0; mPol = 0; mFault = 0;
    mComp = 0; mIntAlert = 0; mArmHigh = 1; mPend = 0; mConv = 0;
    mCompCnt = 0; mIntCnt = 0;
  endtask

  task automatic modelStep();
    logic hi, lo, cond, go;
    int n;
    hi = $signed(sampleData) >= $signed(mHigh);
    lo = $signed(sampleData) <  $signed(mLow);
    n  = needN(mFault);
    if (genCallReset) begin
      modelReset();
    end else begin
      if (sampleValid) begin
        cond = mComp ? lo : hi;
        if (cond) begin
          if (mCompCnt + 1 >= n) begin mComp = !mComp; mCompCnt = 0; end
          else mCompCnt++;
        end else mCompCnt = 0;
      end
      if (!mInt) begin
        mIntAlert = 0; mArmHigh = 1; mIntCnt = 0;
      end else if (mIntAlert) begin
        mIntCnt = 0;
        if (regRead || alertAck || (shutdown && !mShutQ)) mIntAlert = 0;
      end else begin
        cond = mArmHigh ? hi : lo;
        if (sampleValid && cond && (mIntCnt + 1 >= n)) begin
          mIntAlert = 1; mArmHigh = !mArmHigh; mIntCnt = 0;
        end else if (sampleValid) begin
          mIntCnt = cond ? mIntCnt + 1 : 0;
        end
      end
      go = cfgWe && cfgOneShot && shutdown && !mPend;
      mConv = go;
      if (go) mPend = 1;
      else if (sampleValid || !shutdown) mPend = 0;
      if (cfgWe) begin mInt = cfgIntMode; mPol = cfgPolarity; mFault = cfgFaultSel; end
      if (limWe) begin
        if (limSelHigh) mHigh = limData; else mLow = limData;
      end
    end
    mShutQ = shutdown;
  endtask

  task automatic checkOne(input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    modelStep();
    @(negedge clk);
    checkOne("alertPin", alertPin, expPin());
    checkOne("statusBit", statusBit, expStatus());
    checkOne("convStart", convStart, mConv);
    sampleValid = 0; cfgWe = 0; limWe = 0; regRead = 0; alertAck = 0; genCallReset = 0;
  endtask

  task automatic sample(input logic [11:0] t);
    sampleValid = 1; sampleData = t; tick();
  endtask

  task automatic writeCfg(input logic im, input logic pol, input logic [1:0] fs, input logic os);
    cfgWe = 1; cfgIntMode = im; cfgPolarity = pol; cfgFaultSel = fs; cfgOneShot = os; tick();
  endtask

  task automatic writeLim(input logic hiSel, input logic [11:0] v);
    limWe = 1; limSelHigh = hiSel; limData = v; tick();
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    mShutQ = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    curReq = "R1"; tick();
    // R1/R2: default upper limit boundary
    curReq = "R2"; sample(12'h4FF); sample(12'h500);
    // R3: band keeps state, below lower limit releases
    curReq = "R3"; sample(12'h4B0); sample(12'h3FF); sample(12'h4AF);
    // R4: four consecutive with interruption
    curReq = "R4"; writeCfg(0, 0, 2'd2, 0);
    sample(12'h520); sample(12'h520); sample(12'h520); sample(12'h100);
    sample(12'h520); sample(12'h520); sample(12'h520); sample(12'h520);
    writeCfg(0, 0, 2'd3, 0);
    for (int i = 0; i < 7; i++) sample(12'h000);
    writeCfg(0, 0, 2'd1, 0);
    sample(12'h600); sample(12'h600);
    // R9: signed limits and LSB sensitivity
    curReq = "R9"; writeCfg(0, 0, 2'd0, 0);
    writeLim(1, 12'hFF8); writeLim(0, 12'hFF0);
    sample(12'hFF9); sample(12'hFF0); sample(12'hFEF);
    writeLim(1, 12'h501); sample(12'h500); sample(12'h501);
    writeLim(0, 12'h4B1); sample(12'h4B1); sample(12'h4B0);
    // R5/R6/R7: interrupt alternation
    curReq = "R5"; writeCfg(1, 0, 2'd1, 0);
    sample(12'h600); sample(12'h600); sample(12'h000);
    curReq = "R6"; regRead = 1; tick();
    curReq = "R7"; sample(12'h600); sample(12'h600); sample(12'h000); sample(12'h000);
    curReq = "R6"; alertAck = 1; tick();
    curReq = "R7"; sample(12'h000); sample(12'h600); sample(12'h600);
    curReq = "R6"; shutdown = 1; tick(); shutdown = 0; tick();
    // R8: polarity
    curReq = "R8"; writeCfg(1, 1, 2'd0, 0); sample(12'h000); sample(12'h700);
    writeCfg(0, 1, 2'd0, 0); tick();
    // R10: one-shot
    curReq = "R10"; writeCfg(0, 0, 2'd0, 1);
    shutdown = 1; tick();
    writeCfg(0, 0, 2'd0, 1); tick();
    writeCfg(0, 0, 2'd0, 1);
    sample(12'h100);
    writeCfg(0, 0, 2'd0, 1);
    shutdown = 0; tick(); tick();
    // R1: general-call reset
    curReq = "R1"; writeCfg(1, 1, 2'd3, 0); sample(12'h7FF);
    genCallReset = 1; tick(); sample(12'h4FF); sample(12'h500);
    // Random mix
    curReq = "random R2-R10";
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 45) begin
        sampleValid = 1;
        sampleData = ($urandom_range(0, 3) == 0) ? 12'($urandom)
                     : 12'(12'h480 + $urandom_range(0, 160));
      end
      if ($urandom_range(0, 39) == 0) begin
        cfgWe = 1; cfgIntMode = 1'($urandom); cfgPolarity = 1'($urandom);
        cfgFaultSel = 2'($urandom); cfgOneShot = 1'($urandom);
      end
      if ($urandom_range(0, 79) == 0) begin
        limWe = 1; limSelHigh = 1'($urandom);
        limData = 12'(12'h480 + $urandom_range(0, 160));
      end
      if ($urandom_range(0, 19) == 0) regRead = 1;
      if ($urandom_range(0, 29) == 0) alertAck = 1;
      if ($urandom_range(0, 499) == 0) genCallReset = 1;
      if ($urandom_range(0, 49) == 0) shutdown = !shutdown;
      tick();
    end
    finishRun();
  end
endmodule